// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a small synchronous up-counter with a parallel preset, meant to be dropped into a datapath wherever a short cycle count, a loadable timer or a modulo divider is needed. Its state is a `WIDTH`-bit binary count that wraps from all ones back to zero. Four modes are decoded each cycle in a fixed priority: clear, preset from the data inputs, step up by one, and hold.

Two enables gate counting, and both must be high for the count to advance. The carry-in enable also qualifies the terminal-count flag. The flag is driven straight from logic, with no register, so several instances can be chained into one wider synchronous counter. To chain them, feed each stage's flag into the carry-in enable of the next stage, and tie all stages to the same clock.

The parameter `ASYNC_CLR` picks the clear style at elaboration. When it is set, the clear input empties the count at once, with no clock edge needed. When it is clear, the clear input is sampled like any other control and acts on the next rising edge.

Top module: `bin_counter_casc`

## Requirements
- R1: The count is binary modulo 2^WIDTH: stepping from all ones (15 for WIDTH=4) gives zero.
- R2: With ASYNC_CLR=1, a low `rst_n` forces `count` to zero immediately, without waiting for a clock edge, and overrides every other input.
- R3: With ASYNC_CLR=0, a low `rst_n` sampled at a rising edge sets `count` to zero at that edge and overrides preset and stepping; between edges the count keeps its value.
- R4: With `rst_n` high and `load_n` low, the rising edge copies `din` into `count`, whatever the enables are.
- R5: With `rst_n` and `load_n` high and both `en_p` and `en_t` high, each rising edge adds one to `count`.
- R6: With `rst_n` and `load_n` high and either enable low, `count` keeps its value across the edge.
- R7: `tc` is high exactly when `en_t` is high and `count` is all ones; `en_p` has no effect on it, and it follows `en_t` without a clock edge.
- R8: Two instances, where the flag of the low stage drives `en_t` of the high stage, count together as one 2*WIDTH-bit synchronous counter through its full range and wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, immediate or edge-sampled depending on ASYNC_CLR |
| load_n | input | 1 | Active-low preset enable |
| din | input | WIDTH | Preset value |
| en_p | input | 1 | Count enable that does not affect the flag |
| en_t | input | 1 | Carry-in count enable; also qualifies the flag |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag for chaining |

## Verification
The bench steps the counter through the wrap from 15 to 0. A design that saturated or skipped a state there would show up at once. It presets while the enables are high, which catches a priority that lets stepping win over the preset. It pulses the clear in the middle of a clock period on both variants at the same time: the immediate variant must already read zero before the next edge, and the edge-sampled one must not. It also holds the count at 15 with only the carry-in enable high, to catch a flag wrongly gated by the other enable, and runs a two-stage chain through 255 so that a registered or late flag would show up as a skipped or repeated carry in the high stage.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_STEP  = 2'd2,
        MODE_HOLD  = 2'd3
    } ctr_mode_e;

endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
    import ctr_pkg::*;
(
    input  logic      sync_clr,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output ctr_mode_e mode
);

    // fixed priority: clear, preset, step, hold
    always_comb begin
        if (sync_clr)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (en_p && en_t)
            mode = MODE_STEP;
        else
            mode = MODE_HOLD;
    end

endmodule

// File: rtl/ctr_tc_gen.sv
module ctr_tc_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             en_t,
    output logic             tc
);

    // unregistered so a chain ripples the carry within one cycle
    always_comb begin
        tc = en_t & (&cnt);
    end

endmodule

// File: rtl/bin_counter_casc.sv
module bin_counter_casc
    import ctr_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] count,
    output logic             tc
);

    localparam logic [WIDTH-1:0] STEP_ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t    st_d;
    state_t    st_q;
    ctr_mode_e mode;
    logic      sync_clr;

    // edge-sampled clear only exists in the synchronous variant
    assign sync_clr = ASYNC_CLR ? 1'b0 : ~rst_n;

    ctr_mode_dec u_dec (
        .sync_clr (sync_clr),
        .load_n   (load_n),
        .en_p     (en_p),
        .en_t     (en_t),
        .mode     (mode)
    );

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_CLEAR: st_d.cnt = '0;
            MODE_LOAD:  st_d.cnt = din;
            MODE_STEP:  st_d.cnt = st_q.cnt + STEP_ONE;
            MODE_HOLD:  st_d.cnt = st_q.cnt;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    st_q <= '0;
                else
                    st_q <= st_d;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign count = st_q.cnt;

    ctr_tc_gen #(
        .WIDTH (WIDTH)
    ) u_tc (
        .cnt  (st_q.cnt),
        .en_t (en_t),
        .tc   (tc)
    );

endmodule

// File: rtl/bin_counter_casc_chk.sv
module bin_counter_casc_chk #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] count,
    input logic             tc
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    AST_PRESET_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(din)) else $error("preset"); // R4

    AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_p && en_t) |=> count == $past(count) + ONE) else $error("step"); // R5

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_p && en_t)) |=> $stable(count)) else $error("hold"); // R6

    AST_FLAG_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        tc == (en_t && (&count))) else $error("flag"); // R7

    generate
        if (ASYNC_CLR) begin : g_async
            AST_CLEAR_NOW: assert property (@(posedge clk)
                !rst_n |-> count == '0) else $error("async clear"); // R2
        end else begin : g_sync
            AST_CLEAR_EDGE: assert property (@(posedge clk)
                !rst_n |=> count == '0) else $error("sync clear"); // R3
        end
    endgenerate

endmodule

bind bin_counter_casc bin_counter_casc_chk #(
    .WIDTH     (WIDTH),
    .ASYNC_CLR (ASYNC_CLR)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .din    (din),
    .en_p   (en_p),
    .en_t   (en_t),
    .count  (count),
    .tc     (tc)
);

// File: tb/bin_counter_casc_tb.sv
`timescale 1ns/1ps
module bin_counter_casc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din = '0;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [3:0] cnt_a, cnt_s;
    logic       tc_a, tc_s;

    logic       c_rst_n = 1'b0;
    logic       c_en = 1'b0;
    logic [3:0] lo_cnt, hi_cnt;
    logic       lo_tc, hi_tc;

    int total = 0;
    int bad = 0;
    logic [3:0] m = '0;

    typedef struct {
        logic [3:0] cnt;
        logic       tc;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    bin_counter_casc #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .count(cnt_a), .tc(tc_a));

    bin_counter_casc #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_sync (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .count(cnt_s), .tc(tc_s));

    bin_counter_casc #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_lo (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'h0),
        .en_p(c_en), .en_t(c_en), .count(lo_cnt), .tc(lo_tc));

    bin_counter_casc #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_hi (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'h0),
        .en_p(c_en), .en_t(lo_tc), .count(hi_cnt), .tc(hi_tc));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // driver: apply inputs for one edge and queue the expected result
    task automatic step(input logic r, input logic ld, input logic [3:0] d,
                        input logic ep, input logic et, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = r; load_n = ld; din = d; en_p = ep; en_t = et;
        if (!r)           m = '0;
        else if (!ld)     m = d;
        else if (ep && et) m = m + 4'd1;
        it.cnt = m;
        it.tc  = et && (m == 4'hF);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compare both variants after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(cnt_a == it.cnt, {it.tag, " async count"}, cnt_a, it.cnt);
                chk(tc_a == it.tc, {it.tag, " async flag"}, tc_a, it.tc);
                chk(cnt_s == it.cnt, {it.tag, " sync count"}, cnt_s, it.cnt);
                chk(tc_s == it.tc, {it.tag, " sync flag"}, tc_s, it.tc);
            end
        end
    end

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        rst_n = 1'b0;
        #0.5;
        chk(cnt_a == 4'd0, "R2 clear before edge", cnt_a, 0);
        step(0, 1, 0, 0, 0, "R3 reset state");
        step(0, 0, 4'hA, 1, 1, "R3 clear beats preset");
        // R5 stepping, R1 wrap through 15 -> 0
        for (int i = 0; i < 20; i++) step(1, 1, 0, 1, 1, "R5 step R1 wrap");
        step(1, 0, 4'd9, 1, 1, "R4 preset while counting");
        step(1, 0, 4'hE, 0, 0, "R4 preset with enables low");
        step(1, 1, 0, 1, 1, "R5 step to 15");
        step(1, 1, 0, 0, 1, "R7 flag without en_p");
        step(1, 1, 0, 1, 0, "R6 hold en_t low R7 flag off");
        step(1, 1, 0, 0, 0, "R6 hold both low");
        step(1, 1, 0, 1, 1, "R1 wrap to zero");
        step(1, 1, 0, 1, 1, "R5 step");
        step(0, 0, 4'd5, 1, 1, "R3 clear beats preset and step");
        step(1, 0, 4'd7, 0, 0, "R4 preset seven");
        step(1, 1, 0, 0, 1, "R6 hold");
        @(posedge clk);
        #1.5;
        while (sb.size() > 0) #1;
        // R2/R3: clear asserted in mid-period while clock is high
        @(posedge clk);
        #1.25;
        rst_n = 1'b0;
        #0.5;
        chk(cnt_a == 4'd0, "R2 mid-period clear", cnt_a, 0);
        chk(cnt_s == 4'd7, "R3 waits for edge", cnt_s, 7);
        @(posedge clk);
        #1;
        chk(cnt_s == 4'd0, "R3 cleared at edge", cnt_s, 0);
        chk(cnt_a == 4'd0, "R2 stays clear", cnt_a, 0);
        @(negedge clk);
        m = '0;
        step(1, 1, 0, 1, 1, "R5 after release");
        step(1, 1, 0, 1, 1, "R5 after release");
        // R7: flag follows en_t without an edge
        step(1, 0, 4'hF, 0, 0, "R4 preset fifteen");
        @(posedge clk);
        #1.5;
        en_t = 1'b1;
        #0.1;
        chk(tc_a == 1'b1, "R7 flag follows en_t", tc_a, 1);
        chk(cnt_a == 4'hF, "R6 no step from mid-period enable", cnt_a, 15);
        // R8: two-stage chain
        @(negedge clk);
        c_rst_n = 1'b1;
        c_en = 1'b1;
        for (int i = 1; i <= 300; i++) begin
            @(posedge clk);
            #1;
            chk({hi_cnt, lo_cnt} == 8'(i), "R8 chained count", {hi_cnt, lo_cnt}, i % 256);
        end
        #10;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule